// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Lock

This peripheral watches for software that has stopped responding. A down-counter is decremented on each cycle of a tick-enable input. When the counter runs out for the first time, the block latches a raw interrupt status, reloads the counter and, if enabled, raises a level interrupt. If software does not service the interrupt before the counter runs out again, the block latches a reset status and stops the counter. If reset requests are enabled, it then raises a reset request.

Software reaches the block through an APB slave port with no wait states. A key register blocks accidental writes: once locked, only a write to the key register itself takes effect. An integration-test mode drives both outputs directly from a register. Read-only identification words sit at the top of the 4 KB window. The parameter `RESTRICTED` selects a cut-down variant. In that variant the test registers are unmapped, and the control register stays frozen from the moment the interrupt enable has been set.

Top module: `apb_wdog`

## Requirements
- R1: After reset the reload value and the counter both read 0xFFFFFFFF and the counter is running. Control, raw status, reset status, lock state, test-control and test-output all read 0, and both outputs are low.
- R2: A write to the reload register (word offset 0x000) sets the reload value and loads the counter with it in the same cycle. It also restarts a stopped counter. While running, the counter (read at 0x004) decreases by one on each clock with `tick_en` high.
- R3: The counter expires on a tick that finds it at 1 (or 0). On an expiry with raw status clear, raw status (0x010 bit 0) is set and the counter reloads from the reload value.
- R4: On an expiry with raw status already set, reset status is set and the counter stops at 0. Further ticks leave it at 0.
- R5: Any write to the clear register (0x00C) clears raw status and reloads the counter from the reload value.
- R6: Control is at 0x008, with bit 0 as interrupt enable and bit 1 as reset enable. `irq_o` is raw status AND interrupt enable. `rst_req_o` is reset status AND reset enable. The masked status at 0x014 reads raw status AND interrupt enable.
- R7: Writing 0x1ACCE551 to the key register (0xC00) unlocks the block, and any other value locks it. A read of the key register returns 1 when locked and 0 when unlocked. While locked, every other write is ignored.
- R8: When test-control (0xF00) bit 0 is set, `irq_o` follows test-output (0xF04) bit 1 and `rst_req_o` follows test-output bit 0, regardless of status.
- R9: With `RESTRICTED`=1, control writes are ignored once interrupt enable is 1. Offsets 0xF00 and 0xF04 act as unmapped.
- R10: Reads of 0x00C, 0xF04 and unmapped offsets return 0. Writes to the count, status and identification offsets or to unmapped offsets change nothing.
- R11: The identification word k (k = 0..11, at 0xFD0 + 4k) reads {24'h0, k[3:0], 4'h3}, or {24'h0, k[3:0], 4'h6} when `RESTRICTED`=1.
- R12: Every transfer completes with `pready` high and `pslverr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter decrement enable |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 10 | APB word address, bits [11:2] |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq_o | output | 1 | Level interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
On every cycle, assertions check the following:
- The counter never exceeds the reload value.
- Raw status only rises on a tick.
- A rising reset status always leaves the counter stopped.
- A locked block keeps control unchanged.
- The restricted variant keeps control frozen once interrupts are enabled.

Only the bench scenarios can show the values seen at the ports. These include the exact counts after a known number of ticks, the two-stage expiry sequence, the key values, the test-mode output mapping, the identification words and the zero reads of unmapped and write-only offsets.

// File: rtl/apb_wdog.sv
module apb_wdog #(
  parameter bit RESTRICTED = 1'b0,
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:2] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam logic [9:0] A_LOAD = 10'h000;
  localparam logic [9:0] A_CNT  = 10'h001;
  localparam logic [9:0] A_CTRL = 10'h002;
  localparam logic [9:0] A_CLR  = 10'h003;
  localparam logic [9:0] A_RIS  = 10'h004;
  localparam logic [9:0] A_MIS  = 10'h005;
  localparam logic [9:0] A_KEY  = 10'h300;
  localparam logic [9:0] A_TCR  = 10'h3C0;
  localparam logic [9:0] A_TOP  = 10'h3C1;
  localparam logic [9:0] A_ID0  = 10'h3F4;
  localparam logic [31:0] KEY   = 32'h1ACC_E551;
  localparam logic [3:0]  ID_LO = RESTRICTED ? 4'h6 : 4'h3;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic       run_q, ris_q, rst_stat_q, lock_q, tcr_q;
  logic [1:0] ctrl_q, top_q;

  wire acc     = psel & penable;
  wire wr      = acc & pwrite & (~lock_q | (paddr == A_KEY));
  wire wr_load = wr & (paddr == A_LOAD);
  wire wr_clr  = wr & (paddr == A_CLR);
  wire wr_ctrl = wr & (paddr == A_CTRL) & ~(RESTRICTED & ctrl_q[0]);
  wire wr_tcr  = wr & (paddr == A_TCR) & ~RESTRICTED;
  wire wr_top  = wr & (paddr == A_TOP) & ~RESTRICTED;
  wire wr_key  = acc & pwrite & (paddr == A_KEY);
  wire expire  = tick_en & run_q & (cnt_q <= CNT_W'(1)) & ~wr_load & ~wr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q     <= '1;
      cnt_q      <= '1;
      run_q      <= 1'b1;
      ris_q      <= 1'b0;
      rst_stat_q <= 1'b0;
      lock_q     <= 1'b0;
      tcr_q      <= 1'b0;
      top_q      <= '0;
      ctrl_q     <= '0;
    end else begin
      if (wr_load) begin
        load_q <= pwdata[CNT_W-1:0];
        cnt_q  <= pwdata[CNT_W-1:0];
        run_q  <= 1'b1;
      end else if (wr_clr) begin
        cnt_q <= load_q;
      end else if (expire) begin
        if (!ris_q) cnt_q <= load_q;
        else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else if (tick_en && run_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (wr_clr) ris_q <= 1'b0;
      else if (expire) ris_q <= 1'b1;
      if (expire && ris_q) rst_stat_q <= 1'b1;
      if (wr_key) lock_q <= (pwdata != KEY);
      if (wr_ctrl) ctrl_q <= pwdata[1:0];
      if (wr_tcr) tcr_q <= pwdata[0];
      if (wr_top) top_q <= pwdata[1:0];
    end
  end

  assign irq_o     = tcr_q ? top_q[1] : (ris_q & ctrl_q[0]);
  assign rst_req_o = tcr_q ? top_q[0] : (rst_stat_q & ctrl_q[1]);
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;

  wire [9:0] id_k = paddr - A_ID0;

  always_comb begin
    prdata = '0;
    if (paddr >= A_ID0) prdata = {24'h0, id_k[3:0], ID_LO};
    else begin
      case (paddr)
        A_LOAD: prdata = 32'(load_q);
        A_CNT:  prdata = 32'(cnt_q);
        A_CTRL: prdata = {30'h0, ctrl_q};
        A_RIS:  prdata = {31'h0, ris_q};
        A_MIS:  prdata = {31'h0, ris_q & ctrl_q[0]};
        A_KEY:  prdata = {31'h0, lock_q};
        A_TCR:  prdata = RESTRICTED ? 32'h0 : {31'h0, tcr_q};
        default: prdata = '0;
      endcase
    end
  end

  p_cnt_le_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= load_q);
  p_ris_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ris_q) |-> $past(tick_en));
  p_stop_on_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_stat_q) |-> (!run_q && cnt_q == '0));
  p_lock_holds_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && psel && penable && pwrite && paddr == A_CTRL) |=> $stable(ctrl_q));
  p_no_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> (pready && !pslverr));

  generate
    if (RESTRICTED) begin : g_rs
      p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |=> (ctrl_q[0] && $stable(ctrl_q)));
    end
  endgenerate
endmodule

// File: tb/test_apb_wdog.sv
module test_apb_wdog;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_a, prdata_b;
  logic pready_a, pready_b, pslverr_a, pslverr_b;
  logic irq_a, irq_b, rreq_a, rreq_b;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  apb_wdog #(.RESTRICTED(1'b0)) i_apb_wdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel_a), .penable(penable),
    .pwrite(pwrite), .paddr(addr[11:2]), .pwdata(pwdata), .prdata(prdata_a),
    .pready(pready_a), .pslverr(pslverr_a), .irq_o(irq_a), .rst_req_o(rreq_a));

  apb_wdog #(.RESTRICTED(1'b1)) i_apb_wdog_rs (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel_b), .penable(penable),
    .pwrite(pwrite), .paddr(addr[11:2]), .pwdata(pwdata), .prdata(prdata_b),
    .pready(pready_b), .pslverr(pslverr_b), .irq_o(irq_b), .rst_req_o(rreq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit rs, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel_a = !rs; psel_b = rs; addr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input bit rs, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel_a = !rs; psel_b = rs; addr = a; pwrite = 1'b0; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = rs ? prdata_b : prdata_a;
    chk("R12", {30'h0, rs ? pready_b : pready_a, rs ? pslverr_b : pslverr_a}, 32'h2);
    @(negedge clk);
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 12'h000, d); chk("R1 load", d, 32'hFFFF_FFFF);
    rd(0, 12'h004, d); chk("R1 count", d, 32'hFFFF_FFFF);
    tick(1);
    rd(0, 12'h004, d); chk("R1 running", d, 32'hFFFF_FFFE);
    rd(0, 12'h008, d); chk("R1 ctrl", d, 0);
    rd(0, 12'hC00, d); chk("R1 lock", d, 0);
    rd(0, 12'hF00, d); chk("R1 tcr", d, 0);
    chk("R1 outputs", {30'h0, irq_a, rreq_a}, 0);
  endtask

  task automatic t_two_stage();
    logic [31:0] d;
    wr(0, 12'h000, 5);
    rd(0, 12'h004, d); chk("R2 load", d, 5);
    tick(2);
    rd(0, 12'h004, d); chk("R2 decrement", d, 3);
    tick(3);
    rd(0, 12'h010, d); chk("R3 ris", d, 1);
    rd(0, 12'h004, d); chk("R3 reload", d, 5);
    chk("R6 irq masked", {31'h0, irq_a}, 0);
    rd(0, 12'h014, d); chk("R6 mis masked", d, 0);
    wr(0, 12'h008, 3);
    chk("R6 irq", {31'h0, irq_a}, 1);
    rd(0, 12'h014, d); chk("R6 mis", d, 1);
    tick(4);
    chk("R4 no reset early", {31'h0, rreq_a}, 0);
    tick(1);
    chk("R4 reset req", {31'h0, rreq_a}, 1);
    rd(0, 12'h004, d); chk("R4 stopped", d, 0);
    tick(3);
    rd(0, 12'h004, d); chk("R4 stays 0", d, 0);
    wr(0, 12'h000, 9);
    tick(1);
    rd(0, 12'h004, d); chk("R2 restart", d, 8);
    do_reset();
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(0, 12'h000, 3);
    wr(0, 12'h008, 3);
    tick(3);
    chk("R5 irq before", {31'h0, irq_a}, 1);
    tick(1);
    wr(0, 12'h00C, 32'h55);
    chk("R5 irq cleared", {31'h0, irq_a}, 0);
    rd(0, 12'h010, d); chk("R5 ris cleared", d, 0);
    rd(0, 12'h004, d); chk("R5 reload", d, 3);
    tick(2);
    rd(0, 12'h004, d); chk("R5 counting", d, 1);
    chk("R5 no reset", {31'h0, rreq_a}, 0);
    do_reset();
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(0, 12'hC00, 0);
    rd(0, 12'hC00, d); chk("R7 locked", d, 1);
    wr(0, 12'h008, 3);
    rd(0, 12'h008, d); chk("R7 ctrl ignored", d, 0);
    wr(0, 12'h000, 7);
    rd(0, 12'h004, d); chk("R7 load ignored", d, 32'hFFFF_FFFF);
    wr(0, 12'hC00, 32'h1ACC_E550);
    rd(0, 12'hC00, d); chk("R7 wrong key", d, 1);
    wr(0, 12'hC00, 32'h1ACC_E551);
    rd(0, 12'hC00, d); chk("R7 unlocked", d, 0);
    wr(0, 12'h008, 1);
    rd(0, 12'h008, d); chk("R7 ctrl written", d, 1);
    do_reset();
  endtask

  task automatic t_test_mode();
    logic [31:0] d;
    wr(0, 12'hF00, 1);
    rd(0, 12'hF00, d); chk("R8 tcr", d, 1);
    wr(0, 12'hF04, 2);
    chk("R8 irq from bit1", {30'h0, irq_a, rreq_a}, 2);
    wr(0, 12'hF04, 1);
    chk("R8 rst from bit0", {30'h0, irq_a, rreq_a}, 1);
    rd(0, 12'hF04, d); chk("R10 top reads 0", d, 0);
    wr(0, 12'hF00, 0);
    chk("R8 normal again", {30'h0, irq_a, rreq_a}, 0);
    do_reset();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(0, 12'h100, d); chk("R10 unmapped read", d, 0);
    rd(0, 12'h00C, d); chk("R10 clr read", d, 0);
    wr(0, 12'h000, 20);
    wr(0, 12'h004, 4);
    rd(0, 12'h004, d); chk("R10 count ro", d, 20);
    wr(0, 12'h010, 1);
    rd(0, 12'h010, d); chk("R10 ris ro", d, 0);
    wr(0, 12'h100, 32'hFFFF_FFFF);
    rd(0, 12'h008, d); chk("R10 unmapped write", d, 0);
    for (int k = 0; k < 12; k += 5) begin
      rd(0, 12'hFD0 + 12'(4 * k), d); chk("R11 id", d, {24'h0, 4'(k), 4'h3});
      rd(1, 12'hFD0 + 12'(4 * k), d); chk("R11 id rs", d, {24'h0, 4'(k), 4'h6});
    end
    do_reset();
  endtask

  task automatic t_restricted();
    logic [31:0] d;
    wr(1, 12'h008, 2);
    wr(1, 12'h008, 1);
    rd(1, 12'h008, d); chk("R9 ctrl set", d, 1);
    wr(1, 12'h008, 2);
    rd(1, 12'h008, d); chk("R9 ctrl frozen", d, 1);
    wr(1, 12'hF00, 1);
    wr(1, 12'hF04, 3);
    rd(1, 12'hF00, d); chk("R9 tcr unmapped", d, 0);
    chk("R9 outputs unaffected", {30'h0, irq_b, rreq_b}, 0);
    do_reset();
    rd(1, 12'h008, d); chk("R9 reset clears", d, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_reset();
    t_two_stage();
    t_clear();
    t_lock();
    t_test_mode();
    t_unmapped();
    t_restricted();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule